// File: doc/BRIEF.md
# Synthesizer Control Register Serial Loader

This block is a write-only two-wire serial slave that loads the control registers of a frequency synthesizer. It watches the bus clock and data lines through synchronisers in the system clock domain and finds START and STOP conditions. It checks a device address byte that has one bit set by a strap pin, so two such blocks can share one bus. A group-select byte then opens one of two fixed register bursts.

The reference group takes three bytes: a status byte, then the high and then the low byte of the 16-bit reference divider. The main group takes two bytes: the high and then the low byte of the 16-bit main divider. A divider high byte waits in a shadow register, and the whole 16-bit value appears at the output when its low byte is accepted. A divider output therefore never holds one new byte and one old byte. The block acknowledges each byte it accepts by pulling the data line low. After any byte it refuses, it releases the line and stays silent until the next START.

All outputs are plain level signals with no handshake. The bus data line is open-drain: `sda_oe_o` high means the pad pulls the line low.

Top module: `synth_ctrl_i2c`

## Requirements
- R1: After reset `status_o`, `ref_div_o` and `main_div_o` are all zero and `sda_oe_o` is low.
- R2: An address byte with bit 0 equal to 0 (write), bit 1 equal to the level on `addr_sel_i`, and bits 7..2 equal to 110010 is acknowledged.
- R3: An address byte that breaks any part of R2 (fixed bits differ, bit 1 differs from `addr_sel_i`, or bit 0 is 1) is not acknowledged. No later byte is acknowledged and no register changes until the next START.
- R4: In the group-select byte only bits 3..2 matter: 01 opens the reference group, 11 opens the main group, and 00 or 10 is not acknowledged and sends the slave into the ignore state of R3.
- R5: In the reference group the first data byte goes to the status register, the second is the reference divider bits 15..8, and the third is bits 7..0. Each is acknowledged.
- R6: In the main group the first data byte is the main divider bits 15..8 and the second is bits 7..0. Each is acknowledged.
- R7: A divider output changes only when its low byte is acknowledged, and then takes both bytes at once. A transfer that ends after the high byte leaves the output unchanged.
- R8: `status_o` takes the status byte when that byte is acknowledged. The bit map is: bit 7 switching port, bits 6..4 switching outputs 1..3, bit 3 band select (1 = AM, 0 = FM), bit 2 phase-detector test mode, bit 1 phase-detector polarity, bit 0 charge-pump current select.
- R9: A data byte beyond the end of the open group is not acknowledged and changes no register. Every register write is acknowledged.
- R10: A START at any point restarts decoding with a new address byte (repeated start). After a STOP, bus activity without a START is not acknowledged.
- R11: The acknowledge drive begins only while the clock line is low, after the eighth bit of an accepted byte. It is released on the following clock fall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| addr_sel_i | input | 1 | Static strap that picks the variable address bit |
| sda_oe_o | output | 1 | Pull the bus data line low (acknowledge) |
| status_o | output | 8 | Status control byte |
| ref_div_o | output | 16 | Reference divider value |
| main_div_o | output | 16 | Main divider value |

## Verification
The bench mixes seeded random transfers with directed cases, and checks them against a byte-level model of the address, group and burst rules. The random part varies the strap level, address bytes, group codes and burst length. The directed cases target these faults:
- A strap comparison that is inverted or missing would acknowledge the partner device's address.
- A decoder that looks at the wrong select bits would open a group for codes 00 or 10, or reject a valid code whose don't-care bits are set.
- A divider that loads its high byte straight to the output would show a half-written value after a transfer stopped early.
- A burst counter with no end would acknowledge a surplus byte and overwrite a register.
- The repeated-start case catches a slave that waits for STOP before it decodes again.
- The no-START case catches a slave that decodes bytes which follow a STOP.

// File: rtl/synth_i2c_pkg.sv
package synth_i2c_pkg;
  localparam int BYTE_W = 8;
  localparam int DIV_W  = 2 * BYTE_W;
  localparam int CNT_W  = $clog2(BYTE_W + 1);

  localparam logic [5:0] DEV_ID_FIXED  = 6'b110010;
  localparam logic [1:0] GRP_REF_CODE  = 2'b01;
  localparam logic [1:0] GRP_MAIN_CODE = 2'b11;

  localparam int REF_BURST  = 3;
  localparam int MAIN_BURST = 2;

  typedef enum logic [2:0] {
    BS_IDLE,
    BS_ADDR,
    BS_SUB,
    BS_DATA,
    BS_IGNORE
  } bus_state_t;

  typedef enum logic [2:0] {
    WS_STATUS,
    WS_REF_HI,
    WS_REF_LO,
    WS_MAIN_HI,
    WS_MAIN_LO
  } wr_sel_t;
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_lvl,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  localparam int NLINES = 2;

  logic [NLINES-1:0] raw;
  logic [NLINES-1:0] synced;
  logic [NLINES-1:0] prev;

  assign raw = {scl_i, sda_i};

  for (genvar g = 0; g < NLINES; g++) begin : g_line
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '1;
      else        chain <= {chain[STAGES-2:0], raw[g]};
    end
    assign synced[g] = chain[STAGES-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev <= '1;
    else        prev <= synced;
  end

  logic scl_s, sda_s, scl_p, sda_p;
  assign scl_s = synced[1];
  assign sda_s = synced[0];
  assign scl_p = prev[1];
  assign sda_p = prev[0];

  assign scl_lvl   = scl_s;
  assign scl_rise  = scl_s & ~scl_p;
  assign scl_fall  = ~scl_s & scl_p;
  assign start_det = scl_s & scl_p & sda_p & ~sda_s;
  assign stop_det  = scl_s & scl_p & ~sda_p & sda_s;
endmodule

// File: rtl/i2c_ctrl_fsm.sv
module i2c_ctrl_fsm
  import synth_i2c_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              addr_sel_i,
  input  logic              scl_lvl,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_det,
  input  logic              stop_det,
  input  logic              sda_in,
  output logic              sda_oe,
  output logic              wr_en,
  output wr_sel_t           wr_sel,
  output logic [BYTE_W-1:0] wr_data
);
  bus_state_t        st;
  logic [BYTE_W-1:0] shreg;
  logic [CNT_W-1:0]  bit_cnt;
  logic [1:0]        byte_idx;
  logic              grp_main;
  logic              ack_q;

  logic       active, eval, accept;
  bus_state_t nxt_st;
  logic [1:0] nxt_idx;
  logic       nxt_grp;
  wr_sel_t    sel_c;

  assign active = (st == BS_ADDR) || (st == BS_SUB) || (st == BS_DATA);
  assign eval   = active && !ack_q && scl_fall && (bit_cnt == CNT_W'(BYTE_W))
                  && !start_det && !stop_det;

  always_comb begin
    accept  = 1'b0;
    nxt_st  = st;
    nxt_idx = byte_idx;
    nxt_grp = grp_main;
    sel_c   = WS_STATUS;
    case (st)
      BS_ADDR: begin
        if (shreg[7:2] == DEV_ID_FIXED && shreg[1] == addr_sel_i && !shreg[0]) begin
          accept = 1'b1;
          nxt_st = BS_SUB;
        end
      end
      BS_SUB: begin
        if (shreg[3:2] == GRP_REF_CODE) begin
          accept  = 1'b1;
          nxt_st  = BS_DATA;
          nxt_idx = 2'd0;
          nxt_grp = 1'b0;
        end else if (shreg[3:2] == GRP_MAIN_CODE) begin
          accept  = 1'b1;
          nxt_st  = BS_DATA;
          nxt_idx = 2'd0;
          nxt_grp = 1'b1;
        end
      end
      BS_DATA: begin
        if (!grp_main) begin
          accept = (int'(byte_idx) < REF_BURST);
          case (byte_idx)
            2'd0:    sel_c = WS_STATUS;
            2'd1:    sel_c = WS_REF_HI;
            default: sel_c = WS_REF_LO;
          endcase
        end else begin
          accept = (int'(byte_idx) < MAIN_BURST);
          sel_c  = (byte_idx == 2'd0) ? WS_MAIN_HI : WS_MAIN_LO;
        end
        if (accept) nxt_idx = byte_idx + 2'd1;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= BS_IDLE;
      shreg    <= '0;
      bit_cnt  <= '0;
      byte_idx <= '0;
      grp_main <= 1'b0;
      ack_q    <= 1'b0;
    end else if (start_det) begin
      st      <= BS_ADDR;
      bit_cnt <= '0;
      ack_q   <= 1'b0;
    end else if (stop_det) begin
      st    <= BS_IDLE;
      ack_q <= 1'b0;
    end else if (ack_q) begin
      if (scl_fall) begin
        ack_q   <= 1'b0;
        bit_cnt <= '0;
      end
    end else if (active) begin
      if (scl_rise && bit_cnt < CNT_W'(BYTE_W)) begin
        shreg   <= {shreg[BYTE_W-2:0], sda_in};
        bit_cnt <= bit_cnt + 1'b1;
      end else if (eval) begin
        if (accept) begin
          ack_q    <= 1'b1;
          st       <= nxt_st;
          byte_idx <= nxt_idx;
          grp_main <= nxt_grp;
        end else begin
          st <= BS_IGNORE;
        end
      end
    end
  end

  assign sda_oe  = ack_q;
  assign wr_en   = eval && accept && (st == BS_DATA);
  assign wr_sel  = sel_c;
  assign wr_data = shreg;

  AST_ACK_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ack_q) |-> !scl_lvl); // R11
  AST_ACK_ONLY_SELECTED: assert property (@(posedge clk) disable iff (!rst_n)
    ack_q |-> (st == BS_SUB || st == BS_DATA)); // R3
  AST_WRITE_ACKED: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> ack_q); // R9
  AST_IGNORE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (st == BS_IGNORE || st == BS_IDLE) |-> !wr_en); // R10
endmodule

// File: rtl/synth_reg_bank.sv
module synth_reg_bank
  import synth_i2c_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  wr_sel_t           wr_sel,
  input  logic [BYTE_W-1:0] wr_data,
  output logic [BYTE_W-1:0] status_o,
  output logic [DIV_W-1:0]  ref_div_o,
  output logic [DIV_W-1:0]  main_div_o
);
  logic [BYTE_W-1:0] ref_hi_q;
  logic [BYTE_W-1:0] main_hi_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_o   <= '0;
      ref_div_o  <= '0;
      main_div_o <= '0;
      ref_hi_q   <= '0;
      main_hi_q  <= '0;
    end else if (wr_en) begin
      case (wr_sel)
        WS_STATUS:  status_o   <= wr_data;
        WS_REF_HI:  ref_hi_q   <= wr_data;
        WS_REF_LO:  ref_div_o  <= {ref_hi_q, wr_data};
        WS_MAIN_HI: main_hi_q  <= wr_data;
        WS_MAIN_LO: main_div_o <= {main_hi_q, wr_data};
        default: ;
      endcase
    end
  end

  AST_REF_ATOMIC: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ref_div_o) |-> $past(wr_en && wr_sel == WS_REF_LO)); // R7
  AST_MAIN_ATOMIC: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(main_div_o) |-> $past(wr_en && wr_sel == WS_MAIN_LO)); // R7
  AST_STATUS_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(status_o) |-> $past(wr_en && wr_sel == WS_STATUS)); // R8
endmodule

// File: rtl/synth_ctrl_i2c.sv
module synth_ctrl_i2c
  import synth_i2c_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic              addr_sel_i,
  output logic              sda_oe_o,
  output logic [BYTE_W-1:0] status_o,
  output logic [DIV_W-1:0]  ref_div_o,
  output logic [DIV_W-1:0]  main_div_o
);
  logic scl_lvl, scl_rise, scl_fall, start_det, stop_det;
  logic sda_s;
  logic wr_en;
  wr_sel_t wr_sel;
  logic [BYTE_W-1:0] wr_data;

  i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_i     (scl_i),
    .sda_i     (sda_i),
    .scl_lvl   (scl_lvl),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det)
  );

  logic [SYNC_STAGES-1:0] sda_chain;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sda_chain <= '1;
    else        sda_chain <= {sda_chain[SYNC_STAGES-2:0], sda_i};
  end
  assign sda_s = sda_chain[SYNC_STAGES-1];

  i2c_ctrl_fsm u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .addr_sel_i (addr_sel_i),
    .scl_lvl    (scl_lvl),
    .scl_rise   (scl_rise),
    .scl_fall   (scl_fall),
    .start_det  (start_det),
    .stop_det   (stop_det),
    .sda_in     (sda_s),
    .sda_oe     (sda_oe_o),
    .wr_en      (wr_en),
    .wr_sel     (wr_sel),
    .wr_data    (wr_data)
  );

  synth_reg_bank u_bank (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .wr_sel     (wr_sel),
    .wr_data    (wr_data),
    .status_o   (status_o),
    .ref_div_o  (ref_div_o),
    .main_div_o (main_div_o)
  );
endmodule

// File: tb/synth_ctrl_i2c_tb.sv
module synth_ctrl_i2c_tb;
  localparam int Q = 8;
  localparam int H = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic addr_sel = 1'b0;
  logic sda_oe;
  logic sda_line;
  logic [7:0]  status;
  logic [15:0] ref_div, main_div;

  always #5 clk = ~clk;
  assign sda_line = sda_m & ~sda_oe;

  synth_ctrl_i2c u_dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .scl_i      (scl_m),
    .sda_i      (sda_line),
    .addr_sel_i (addr_sel),
    .sda_oe_o   (sda_oe),
    .status_o   (status),
    .ref_div_o  (ref_div),
    .main_div_o (main_div)
  );

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  int m_state;
  bit m_grp;
  int m_idx;
  logic [7:0]  exp_status = 8'h00;
  logic [15:0] exp_ref = 16'h0, exp_main = 16'h0;
  logic [7:0]  exp_ref_hi = 8'h00, exp_main_hi = 8'h00;
  logic [7:0]  pkt [8];

  task automatic wait_clks(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic i2c_start();
    sda_m = 1'b1; wait_clks(Q);
    scl_m = 1'b1; wait_clks(H);
    sda_m = 1'b0; wait_clks(H);
    scl_m = 1'b0; wait_clks(Q);
  endtask

  task automatic i2c_stop();
    sda_m = 1'b0; wait_clks(Q);
    scl_m = 1'b1; wait_clks(H);
    sda_m = 1'b1; wait_clks(H);
  endtask

  task automatic send_byte(input logic [7:0] b, output bit acked);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; wait_clks(Q);
      scl_m = 1'b1; wait_clks(H);
      scl_m = 1'b0; wait_clks(Q);
    end
    sda_m = 1'b1; wait_clks(Q);
    scl_m = 1'b1; wait_clks(H / 2);
    acked = !sda_line;
    wait_clks(H / 2);
    scl_m = 1'b0; wait_clks(Q);
  endtask

  task automatic model_byte(input logic [7:0] b, output bit ack, output string req);
    ack = 1'b0;
    req = "R3";
    case (m_state)
      0: begin
        ack = (b[7:2] == 6'b110010) && (b[1] == addr_sel) && !b[0];
        req = ack ? "R2" : "R3";
        m_state = ack ? 1 : 3;
      end
      1: begin
        req = "R4";
        if (b[3:2] == 2'b01) begin ack = 1'b1; m_grp = 1'b0; m_idx = 0; m_state = 2; end
        else if (b[3:2] == 2'b11) begin ack = 1'b1; m_grp = 1'b1; m_idx = 0; m_state = 2; end
        else m_state = 3;
      end
      2: begin
        if (!m_grp) begin
          req = "R5";
          case (m_idx)
            0: begin ack = 1'b1; exp_status = b; req = "R8"; end
            1: begin ack = 1'b1; exp_ref_hi = b; end
            2: begin ack = 1'b1; exp_ref = {exp_ref_hi, b}; end
            default: begin ack = 1'b0; req = "R9"; end
          endcase
        end else begin
          req = "R6";
          case (m_idx)
            0: begin ack = 1'b1; exp_main_hi = b; end
            1: begin ack = 1'b1; exp_main = {exp_main_hi, b}; end
            default: begin ack = 1'b0; req = "R9"; end
          endcase
        end
        if (ack) m_idx++;
        else m_state = 3;
      end
      default: begin ack = 1'b0; req = "R3"; end
    endcase
  endtask

  task automatic run_xfer(input int n, input bit end_stop);
    bit e, got;
    string req;
    i2c_start();
    m_state = 0;
    for (int i = 0; i < n; i++) begin
      model_byte(pkt[i], e, req);
      send_byte(pkt[i], got);
      check(got == e, req, "acknowledge", 32'(got), 32'(e));
    end
    if (end_stop) i2c_stop();
  endtask

  task automatic check_regs(input string tag);
    check(status == exp_status, "R8", {tag, " status"}, 32'(status), 32'(exp_status));
    check(ref_div == exp_ref, "R5", {tag, " reference divider"}, 32'(ref_div), 32'(exp_ref));
    check(main_div == exp_main, "R6", {tag, " main divider"}, 32'(main_div), 32'(exp_main));
  endtask

  function automatic logic [7:0] good_addr(input logic s);
    return {6'b110010, s, 1'b0};
  endfunction

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL R10 watchdog: actual hang expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    bit got;
    void'($urandom(32'h1234abcd));
    wait_clks(5);
    rst_n = 1'b1;
    wait_clks(5);
    // R1 reset state
    check(status == 8'h00 && ref_div == 16'h0 && main_div == 16'h0, "R1", "reset registers",
          {8'h0, status, ref_div[7:0], main_div[7:0]}, 32'h0);
    check(sda_oe == 1'b0, "R1", "reset drive", 32'(sda_oe), 32'h0);

    // R5 R8 full reference burst
    addr_sel = 1'b0;
    pkt[0] = good_addr(1'b0); pkt[1] = 8'h04; pkt[2] = 8'hA5; pkt[3] = 8'h12; pkt[4] = 8'h34;
    run_xfer(5, 1'b1); check_regs("ref burst");

    // R6 main burst
    pkt[0] = good_addr(1'b0); pkt[1] = 8'h0C; pkt[2] = 8'hBE; pkt[3] = 8'hEF;
    run_xfer(4, 1'b1); check_regs("main burst");

    // R4 don't-care select bits set
    pkt[0] = good_addr(1'b0); pkt[1] = 8'hF7; pkt[2] = 8'h3C; pkt[3] = 8'h00; pkt[4] = 8'h02;
    run_xfer(5, 1'b1); check_regs("dont-care select");

    // R7 partial divider write
    pkt[0] = good_addr(1'b0); pkt[1] = 8'h0C; pkt[2] = 8'h55;
    run_xfer(3, 1'b0);
    check(main_div == exp_main, "R7", "main after high byte", 32'(main_div), 32'(exp_main));
    i2c_stop();
    wait_clks(4);
    check(main_div == exp_main, "R7", "main after stop", 32'(main_div), 32'(exp_main));

    // R3 strap mismatch, then matching partner address
    addr_sel = 1'b1;
    pkt[0] = good_addr(1'b0); pkt[1] = 8'h04; pkt[2] = 8'hFF; pkt[3] = 8'hFF; pkt[4] = 8'hFF;
    run_xfer(5, 1'b1); check_regs("strap mismatch");
    pkt[0] = good_addr(1'b1); pkt[1] = 8'h0C; pkt[2] = 8'h13; pkt[3] = 8'h57;
    run_xfer(4, 1'b1); check_regs("strap match");

    // R3 read direction bit
    pkt[0] = good_addr(1'b1) | 8'h01; pkt[1] = 8'h04; pkt[2] = 8'h77;
    run_xfer(3, 1'b1); check_regs("read bit");

    // R4 undefined select code
    pkt[0] = good_addr(1'b1); pkt[1] = 8'h08; pkt[2] = 8'h99; pkt[3] = 8'h99;
    run_xfer(4, 1'b1); check_regs("bad select");

    // R9 surplus byte
    pkt[0] = good_addr(1'b1); pkt[1] = 8'h0C; pkt[2] = 8'h21; pkt[3] = 8'h43; pkt[4] = 8'h65;
    run_xfer(5, 1'b1);
    check(main_div == 16'h2143, "R9", "main after surplus", 32'(main_div), 32'h2143);
    check_regs("surplus");

    // R10 repeated start mid burst
    pkt[0] = good_addr(1'b1); pkt[1] = 8'h04; pkt[2] = 8'h11;
    run_xfer(3, 1'b0);
    pkt[0] = good_addr(1'b1); pkt[1] = 8'h0C; pkt[2] = 8'hCA; pkt[3] = 8'hFE;
    run_xfer(4, 1'b1);
    check(status == 8'h11 && main_div == 16'hCAFE, "R10", "repeated start",
          {8'h0, status, main_div}, {8'h0, 8'h11, 16'hCAFE});

    // R10 bytes after STOP without START
    send_byte(good_addr(1'b1), got);
    check(!got, "R10", "address without start", 32'(got), 32'h0);
    send_byte(8'h0C, got);
    check(!got, "R10", "select without start", 32'(got), 32'h0);
    i2c_stop();
    check_regs("no start");

    // random transfers
    for (int t = 0; t < 40; t++) begin
      int n;
      logic [1:0] codes [4];
      codes[0] = 2'b01; codes[1] = 2'b11; codes[2] = 2'b01; codes[3] = 2'b11;
      addr_sel = 1'($urandom % 2);
      wait_clks(4);
      n = 2 + int'($urandom % 6);
      if (($urandom % 10) < 8) pkt[0] = good_addr(addr_sel);
      else pkt[0] = 8'($urandom);
      pkt[1] = 8'($urandom);
      if (($urandom % 5) != 0) pkt[1][3:2] = codes[$urandom % 4];
      for (int i = 2; i < 8; i++) pkt[i] = 8'($urandom);
      run_xfer(n, 1'b1);
      check_regs("random");
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule